// File: doc/BRIEF.md
# Serial Audio-Link Register Command Decoder

This block sits on the codec side of a frame-based serial audio link. Each frame, the upstream deserializer presents three words: the 16-bit tag slot, the 20-bit command slot and the 20-bit data slot. At the frame-end pulse the decoder decides whether the frame holds a register access meant for this codec. If it does, it issues one register-file read or write strobe, together with a word address and the 16-bit write value. If the command is addressed to this codec but cannot be carried out, the decoder raises an error pulse instead.

The codec can act in a primary or a secondary role, and the two roles use opposite slot-valid tag rules. The role and the 2-bit codec ID come from a configuration input that is captured only at frame boundaries. A write is atomic: its command and its data must arrive in the same frame. An odd register index never reaches the register file, because the registers are word-addressed.

Top module: `reg_cmd_decoder`

## Requirements
- R1: While reset (synchronous, active high) is applied, `rd_stb`, `wr_stb` and `err_stb` are low and `word_addr` and `wr_data` are zero.
- R2: The first `frame_end` pulse after reset is released only captures the configuration. It produces no read, write or error strobe, whatever the slots hold.
- R3: `cfg_secondary` and `cfg_codec_id` are captured at each `frame_end` pulse. The captured value governs the decode at the next `frame_end`, so a configuration change takes effect one frame later.
- R4: No strobe of any kind is issued unless both of these hold: tag bit 15 (frame valid) is 1, and tag bits 1:0 equal the captured codec ID.
- R5: Primary role, read. With tag bit 14 (slot-1 valid) set, command bit 19 = 1 and an even 7-bit index in command bits 18:12, the decoder pulses `rd_stb`. It sets `word_addr` to index bits 6:1 and leaves `wr_data` unchanged, because the data slot is ignored for reads.
- R6: Primary role, write. With tag bits 14 and 13 (slot-2 valid) both set, command bit 19 = 0 and an even index, the decoder pulses `wr_stb`. It loads `word_addr` with index bits 6:1 and `wr_data` with data-slot bits 19:4; data-slot bits 3:0 are ignored.
- R7: Primary role, partial write. A write command with tag bit 14 set and tag bit 13 clear gives `err_stb` and no `wr_stb`. Nothing is held over, so a following frame with only tag bit 13 set produces no strobe.
- R8: Primary role. With tag bit 14 clear, no strobe and no error are issued.
- R9: Secondary role. A read or write is accepted only when tag bits 14 and 13 are both clear; the encodings are those of R5 and R6. If either tag bit is set, the frame gives no strobe and no error.
- R10: A qualified command with index bit 0 set gives `err_stb`. It gives no `rd_stb` or `wr_stb`, and `word_addr` and `wr_data` keep their values.
- R11: Strobes are high for exactly one cycle: the cycle after the clock edge at which `frame_end` is high. At most one of the three strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle pulse; the slots are valid and are decoded on this cycle |
| tag_slot | input | 16 | Tag slot: bit 15 frame valid, 14 slot-1 valid, 13 slot-2 valid, 1:0 codec ID |
| cmd_slot | input | 20 | Command slot: bit 19 direction (1 = read), bits 18:12 register index |
| data_slot | input | 20 | Data slot: bits 19:4 write value, bits 3:0 reserved |
| cfg_secondary | input | 1 | 1 selects the secondary role, 0 the primary role |
| cfg_codec_id | input | 2 | This codec's ID |
| rd_stb | output | 1 | Register read strobe |
| wr_stb | output | 1 | Register write strobe |
| err_stb | output | 1 | Rejected-command pulse |
| word_addr | output | 6 | Word address (index bits 6:1) |
| wr_data | output | 16 | Write value |

## Verification
Every result is due one clock after the edge at which `frame_end` is high; the configuration is the exception and takes effect at the following `frame_end`. The bench drives a frame on a falling edge and holds `frame_end` high across one rising edge. It samples the strobes, address and data on the next falling edge, then samples the strobes once more one cycle later to confirm they have dropped. Cases that must be ignored are checked at the outputs: the strobes stay low, and the held address and data are compared with their earlier values.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    localparam int SLOT_W   = 20;
    localparam int TAG_W    = 16;
    localparam int FV_BIT   = 15;
    localparam int S1_BIT   = 14;
    localparam int S2_BIT   = 13;
    localparam int ID_W     = 2;
    localparam int IDX_W    = 7;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = IDX_W - 1;
    localparam int DIR_BIT  = SLOT_W - 1;
    localparam int IDX_LSB  = DIR_BIT - IDX_W;
    localparam int DATA_LSB = SLOT_W - DATA_W;

    typedef struct packed {
        logic            secondary;
        logic [ID_W-1:0] id;
    } role_cfg_t;

    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_READ   = 2'd1,
        DEC_WRITE  = 2'd2,
        DEC_REJECT = 2'd3
    } dec_kind_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_out_t;
endpackage

// File: rtl/rcd_tag_qualifier.sv
module rcd_tag_qualifier
    import rcd_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    input  role_cfg_t        cfg,
    output logic             addressed,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             wr_partial
);
    logic s1_valid;
    logic s2_valid;
    logic unused_tag_bits;

    assign s1_valid        = tag[S1_BIT];
    assign s2_valid        = tag[S2_BIT];
    assign unused_tag_bits = ^tag[S2_BIT-1:ID_W];

    always_comb begin
        addressed = tag[FV_BIT] && (tag[ID_W-1:0] == cfg.id);
        if (cfg.secondary) begin
            rd_ok      = !s1_valid && !s2_valid;
            wr_ok      = !s1_valid && !s2_valid;
            wr_partial = 1'b0;
        end else begin
            rd_ok      = s1_valid;
            wr_ok      = s1_valid && s2_valid;
            wr_partial = s1_valid && !s2_valid;
        end
    end

    // R9: in the secondary role a partial write is never flagged
    always_comb begin
        if (cfg.secondary) begin
            a_r9_no_partial_secondary: assert (!wr_partial);
        end
    end
endmodule

// File: rtl/rcd_cmd_classifier.sv
module rcd_cmd_classifier
    import rcd_pkg::*;
(
    input  logic [SLOT_W-1:0] cmd,
    input  logic [SLOT_W-1:0] data,
    input  logic              addressed,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic              wr_partial,
    output dec_kind_t         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    logic [IDX_W-1:0] index;
    logic             is_read;
    logic             odd_index;
    logic             unused_low_bits;

    assign index           = cmd[DIR_BIT-1 -: IDX_W];
    assign is_read         = cmd[DIR_BIT];
    assign odd_index       = index[0];
    assign addr            = index[IDX_W-1:1];
    assign wdata           = data[SLOT_W-1:DATA_LSB];
    assign unused_low_bits = ^{cmd[IDX_LSB-1:0], data[DATA_LSB-1:0]};

    always_comb begin
        kind = DEC_NONE;
        if (addressed) begin
            if (is_read) begin
                if (rd_ok) begin
                    kind = odd_index ? DEC_REJECT : DEC_READ;
                end
            end else begin
                if (wr_ok) begin
                    kind = odd_index ? DEC_REJECT : DEC_WRITE;
                end else if (wr_partial) begin
                    kind = DEC_REJECT;
                end
            end
        end
    end

    // R10: an odd index is never accepted as a read or write
    always_comb begin
        if (kind == DEC_READ || kind == DEC_WRITE) begin
            a_r10_even_only: assert (!cmd[IDX_LSB]);
        end
    end
endmodule

// File: rtl/rcd_frame_gate.sv
module rcd_frame_gate
    import rcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_end,
    input  logic            cfg_secondary,
    input  logic [ID_W-1:0] cfg_codec_id,
    output logic            armed,
    output role_cfg_t       cfg_active
);
    typedef struct packed {
        logic      armed;
        role_cfg_t cfg;
    } gate_state_t;

    gate_state_t st_d;
    gate_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.armed         = 1'b1;
            st_d.cfg.secondary = cfg_secondary;
            st_d.cfg.id        = cfg_codec_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed      = st_q.armed;
    assign cfg_active = st_q.cfg;

    // R3: the active configuration moves only at a frame boundary
    a_r3_cfg_frame_only: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_active));
endmodule

// File: rtl/reg_cmd_decoder.sv
module reg_cmd_decoder
    import rcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_end,
    input  logic [TAG_W-1:0]    tag_slot,
    input  logic [SLOT_W-1:0]   cmd_slot,
    input  logic [SLOT_W-1:0]   data_slot,
    input  logic                cfg_secondary,
    input  logic [ID_W-1:0]     cfg_codec_id,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic                err_stb,
    output logic [ADDR_W-1:0]   word_addr,
    output logic [DATA_W-1:0]   wr_data
);
    logic              armed;
    role_cfg_t         cfg_active;
    logic              addressed;
    logic              rd_ok;
    logic              wr_ok;
    logic              wr_partial;
    dec_kind_t         kind;
    logic [ADDR_W-1:0] cand_addr;
    logic [DATA_W-1:0] cand_data;

    cmd_out_t out_d;
    cmd_out_t out_q;

    rcd_frame_gate u_gate (
        .clk           (clk),
        .rst           (rst),
        .frame_end     (frame_end),
        .cfg_secondary (cfg_secondary),
        .cfg_codec_id  (cfg_codec_id),
        .armed         (armed),
        .cfg_active    (cfg_active)
    );

    rcd_tag_qualifier u_qual (
        .tag        (tag_slot),
        .cfg        (cfg_active),
        .addressed  (addressed),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .wr_partial (wr_partial)
    );

    rcd_cmd_classifier u_class (
        .cmd        (cmd_slot),
        .data       (data_slot),
        .addressed  (addressed),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .wr_partial (wr_partial),
        .kind       (kind),
        .addr       (cand_addr),
        .wdata      (cand_data)
    );

    always_comb begin
        out_d     = out_q;
        out_d.rd  = 1'b0;
        out_d.wr  = 1'b0;
        out_d.err = 1'b0;
        if (frame_end && armed) begin
            unique case (kind)
                DEC_READ: begin
                    out_d.rd   = 1'b1;
                    out_d.addr = cand_addr;
                end
                DEC_WRITE: begin
                    out_d.wr   = 1'b1;
                    out_d.addr = cand_addr;
                    out_d.data = cand_data;
                end
                DEC_REJECT: begin
                    out_d.err = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_stb    = out_q.rd;
    assign wr_stb    = out_q.wr;
    assign err_stb   = out_q.err;
    assign word_addr = out_q.addr;
    assign wr_data   = out_q.data;

    // R11: strobes only in the cycle after a frame-end edge
    a_r11_after_frame_end: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb || err_stb) |-> $past(frame_end));

    // R11: never two strobes at once
    a_r11_one_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, wr_stb, err_stb}));

    // R2: the arming frame is silent
    a_r2_first_frame_silent: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !armed) |=> !(rd_stb || wr_stb || err_stb));

    // R5: a read leaves the write value untouched
    a_r5_read_keeps_data: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> $stable(wr_data));

    // R10: a rejected command leaves address and data untouched
    a_r10_error_holds: assert property (@(posedge clk) disable iff (rst)
        err_stb |-> ($stable(word_addr) && $stable(wr_data)));
endmodule

// File: tb/reg_cmd_decoder_bench.sv
module reg_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_end = 1'b0;
    logic [15:0] tag_slot = '0;
    logic [19:0] cmd_slot = '0;
    logic [19:0] data_slot = '0;
    logic        cfg_secondary = 1'b0;
    logic [1:0]  cfg_codec_id = 2'd0;
    logic        rd_stb;
    logic        wr_stb;
    logic        err_stb;
    logic [5:0]  word_addr;
    logic [15:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    reg_cmd_decoder u_reg_cmd_decoder (
        .clk           (clk),
        .rst           (rst),
        .frame_end     (frame_end),
        .tag_slot      (tag_slot),
        .cmd_slot      (cmd_slot),
        .data_slot     (data_slot),
        .cfg_secondary (cfg_secondary),
        .cfg_codec_id  (cfg_codec_id),
        .rd_stb        (rd_stb),
        .wr_stb        (wr_stb),
        .err_stb       (err_stb),
        .word_addr     (word_addr),
        .wr_data       (wr_data)
    );

    function automatic logic [15:0] mk_tag(logic fv, logic s1, logic s2, logic [1:0] id);
        return {fv, s1, s2, 11'b0, id};
    endfunction

    function automatic logic [19:0] mk_cmd(logic rd, logic [6:0] idx);
        return {rd, idx, 12'b0};
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // drive one frame; the sample is taken one cycle after the frame_end edge
    task automatic send_frame(logic [15:0] t, logic [19:0] c, logic [19:0] d);
        @(negedge clk);
        tag_slot  = t;
        cmd_slot  = c;
        data_slot = d;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic expect_out(string req, logic rd, logic wr, logic er,
                              logic [5:0] ad, logic [15:0] dt);
        check(req, "rd_stb", {31'b0, rd_stb}, {31'b0, rd});
        check(req, "wr_stb", {31'b0, wr_stb}, {31'b0, wr});
        check(req, "err_stb", {31'b0, err_stb}, {31'b0, er});
        check(req, "word_addr", {26'b0, word_addr}, {26'b0, ad});
        check(req, "wr_data", {16'b0, wr_data}, {16'b0, dt});
    endtask

    task automatic expect_quiet_next(string req);
        @(negedge clk);
        check(req, "strobes cleared", {29'b0, rd_stb, wr_stb, err_stb}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 1'b0, 6'd0, 16'd0);
        rst = 1'b0;
    endtask

    task automatic t_first_frame;
        send_frame(mk_tag(1, 1, 1, 2'd0), mk_cmd(0, 7'h04), {16'h5555, 4'h0});
        expect_out("R2", 1'b0, 1'b0, 1'b0, 6'd0, 16'd0);
    endtask

    task automatic t_primary_read;
        send_frame(mk_tag(1, 1, 0, 2'd0), mk_cmd(1, 7'h26), {16'h7777, 4'h3});
        expect_out("R5", 1'b1, 1'b0, 1'b0, 6'h13, 16'd0);
        expect_quiet_next("R11");
    endtask

    task automatic t_primary_write;
        send_frame(mk_tag(1, 1, 1, 2'd0), mk_cmd(0, 7'h02), {16'hBEEF, 4'hA});
        expect_out("R6", 1'b0, 1'b1, 1'b0, 6'h01, 16'hBEEF);
        expect_quiet_next("R11");
        send_frame(mk_tag(1, 1, 1, 2'd0), mk_cmd(1, 7'h10), {16'h1234, 4'hF});
        expect_out("R5", 1'b1, 1'b0, 1'b0, 6'h08, 16'hBEEF);
    endtask

    task automatic t_not_addressed;
        send_frame(mk_tag(0, 1, 1, 2'd0), mk_cmd(0, 7'h0A), {16'h0001, 4'h0});
        expect_out("R4", 1'b0, 1'b0, 1'b0, 6'h08, 16'hBEEF);
        send_frame(mk_tag(1, 1, 1, 2'd2), mk_cmd(0, 7'h0A), {16'h0002, 4'h0});
        expect_out("R4", 1'b0, 1'b0, 1'b0, 6'h08, 16'hBEEF);
    endtask

    task automatic t_partial_write;
        send_frame(mk_tag(1, 1, 0, 2'd0), mk_cmd(0, 7'h0C), {16'hAAAA, 4'h0});
        expect_out("R7", 1'b0, 1'b0, 1'b1, 6'h08, 16'hBEEF);
        send_frame(mk_tag(1, 0, 1, 2'd0), mk_cmd(0, 7'h0C), {16'hAAAA, 4'h0});
        expect_out("R7", 1'b0, 1'b0, 1'b0, 6'h08, 16'hBEEF);
    endtask

    task automatic t_no_slot1;
        send_frame(mk_tag(1, 0, 0, 2'd0), mk_cmd(1, 7'h20), {16'h0, 4'h0});
        expect_out("R8", 1'b0, 1'b0, 1'b0, 6'h08, 16'hBEEF);
    endtask

    task automatic t_odd_index;
        send_frame(mk_tag(1, 1, 1, 2'd0), mk_cmd(0, 7'h03), {16'hCAFE, 4'h0});
        expect_out("R10", 1'b0, 1'b0, 1'b1, 6'h08, 16'hBEEF);
        expect_quiet_next("R11");
        send_frame(mk_tag(1, 1, 0, 2'd0), mk_cmd(1, 7'h7F), {16'h0, 4'h0});
        expect_out("R10", 1'b0, 1'b0, 1'b1, 6'h08, 16'hBEEF);
    endtask

    task automatic t_role_change;
        @(negedge clk);
        cfg_secondary = 1'b1;
        cfg_codec_id  = 2'd1;
        // still decoded as primary ID 0: ID 1 does not match yet
        send_frame(mk_tag(1, 0, 0, 2'd1), mk_cmd(0, 7'h5E), {16'h0F0F, 4'h0});
        expect_out("R3", 1'b0, 1'b0, 1'b0, 6'h08, 16'hBEEF);
        send_frame(mk_tag(1, 0, 0, 2'd1), mk_cmd(0, 7'h5E), {16'h0F0F, 4'h5});
        expect_out("R9", 1'b0, 1'b1, 1'b0, 6'h2F, 16'h0F0F);
        send_frame(mk_tag(1, 0, 0, 2'd1), mk_cmd(1, 7'h28), {16'hFFFF, 4'h0});
        expect_out("R9", 1'b1, 1'b0, 1'b0, 6'h14, 16'h0F0F);
        send_frame(mk_tag(1, 1, 0, 2'd1), mk_cmd(1, 7'h2A), {16'h0, 4'h0});
        expect_out("R9", 1'b0, 1'b0, 1'b0, 6'h14, 16'h0F0F);
        send_frame(mk_tag(1, 1, 1, 2'd1), mk_cmd(0, 7'h2C), {16'h1111, 4'h0});
        expect_out("R9", 1'b0, 1'b0, 1'b0, 6'h14, 16'h0F0F);
        send_frame(mk_tag(1, 0, 0, 2'd1), mk_cmd(0, 7'h31), {16'h2222, 4'h0});
        expect_out("R10", 1'b0, 1'b0, 1'b1, 6'h14, 16'h0F0F);
    endtask

    task automatic t_reset_rearm;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 1'b0, 6'd0, 16'd0);
        rst = 1'b0;
        send_frame(mk_tag(1, 0, 0, 2'd1), mk_cmd(1, 7'h28), {16'h0, 4'h0});
        expect_out("R2", 1'b0, 1'b0, 1'b0, 6'd0, 16'd0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_frame();
        t_primary_read();
        t_primary_write();
        t_not_addressed();
        t_partial_write();
        t_no_slot1();
        t_odd_index();
        t_role_change();
        t_reset_rearm();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule